// File: doc/BRIEF.md
# USB Type-C Attach and Orientation Detector

This block holds the configuration-channel attach logic of a USB Type-C port. Comparators outside the block turn the voltage on each CC line into a three-bit class code, and a second comparator reports whether VBUS is above its threshold. A free-running millisecond tick paces all debouncing. The block filters the pair of CC codes and the VBUS flag. It then decides whether a partner is attached, which CC line carries the termination, and, in the sink role, which current level the source advertises.

In the source role, the block looks for a sink pull-down on one line, possibly with a powered-cable pull-down on the other. A pull-down of the powered-cable kind on both lines is reported as an audio accessory. In the sink role, the block looks for a source pull-up on exactly one line. A sink attach is declared only once VBUS has also passed its own debounce. The debounce time for the CC pair comes from a two-bit select input. The outputs go straight to pins or to a register file.

Top module: `tc_attach_det`

## Requirements
- R1: While reset is held and right after it is released, `attached`=0, `orient`=0, `cur_mode`=00, `id_n`=1 and `audio_n`=1.
- R2: Each CC line is coded as 000 open, 001 Ra, 010 Rd, 100 Rp default, 101 Rp 1.5 A and 110 Rp 3 A; any other code counts as open. The pair of codes must stay unchanged for N counted `ms_tick` pulses before the attach logic sees it. N is 168, 118, 134 or 152 for `deb_sel` values 00, 01, 10 and 11. Any change in the pair restarts the count, and cycles without a tick do not count.
- R3: In the source role (`role_src`=1), Rd on one line and no Rd on the other gives `attached`=1 and `id_n`=0. `orient` is 0 when the Rd is on CC1 and 1 when it is on CC2.
- R4: In the source role, Ra on one line with Rd on the other is an attach, and `orient` follows the Rd line.
- R5: In the source role, Ra on both lines drives `audio_n` low and keeps `attached` low. `audio_n` goes back high when that pair stops holding.
- R6: In the sink role (`role_src`=0), a pull-up code on one line with the other line open gives `attached`=1, provided VBUS is debounced present. `orient` follows the pull-up line. `cur_mode` is 01 for default, 10 for 1.5 A and 11 for 3 A.
- R7: In the sink role, no attach is declared until `vbus_raw` has been high for 2 counted ticks.
- R8: A detach clears `attached`, `orient` and `cur_mode`. A detach happens when the debounced active line no longer shows the termination that made the attach. In the sink role, a debounced loss of VBUS also causes a detach.
- R9: `cur_mode` is 00 unless the block is attached as a sink. `id_n` is low only while the block is attached as a source.
- R10: A change of `role_src` while attached or in the audio state returns the block to unattached. In the source role, pull-up codes never cause an attach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| role_src | input | 1 | 1 = source role, 0 = sink role |
| deb_sel | input | 2 | CC debounce time select |
| cc1_state | input | 3 | Class code of CC1 |
| cc2_state | input | 3 | Class code of CC2 |
| vbus_raw | input | 1 | VBUS above threshold, undebounced |
| attached | output | 1 | Partner attached |
| orient | output | 1 | 0 = CC1 active, 1 = CC2 active |
| cur_mode | output | 2 | Advertised source current when sink |
| id_n | output | 1 | Low while attached as source |
| audio_n | output | 1 | Low while audio accessory present |

## Verification
The hardest case to reach is a sink attach whose timing hinges on two independent filters that share a sparse tick. The CC pair has to settle over many hundreds of clocks while VBUS settles over only a few ticks. The bench reaches this case by slowing the tick to one pulse in four cycles and choosing the longest non-default window. It then sets VBUS before the pull-up code, so the CC filter alone sets the attach cycle. It also injects a one-cycle glitch in the middle of a source debounce to show that the count restarts. A behavioural model runs beside the design and is compared with it on every clock.

// File: rtl/tc_attach_pkg.sv
package tc_attach_pkg;

  localparam logic [2:0] CC_OPEN    = 3'b000;
  localparam logic [2:0] CC_RA      = 3'b001;
  localparam logic [2:0] CC_RD      = 3'b010;
  localparam logic [2:0] CC_RP_DEF  = 3'b100;
  localparam logic [2:0] CC_RP_MED  = 3'b101;
  localparam logic [2:0] CC_RP_HIGH = 3'b110;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SRC  = 2'd1,
    ST_SNK  = 2'd2,
    ST_AUD  = 2'd3
  } att_state_e;

  function automatic logic is_pullup(input logic [2:0] c);
    return c[2] && (c[1:0] != 2'b11);
  endfunction

  function automatic logic is_open(input logic [2:0] c);
    return !(c == CC_RA || c == CC_RD || is_pullup(c));
  endfunction

  function automatic logic [1:0] pullup_mode(input logic [2:0] c);
    return c[1:0] + 2'd1;
  endfunction

endpackage

// File: rtl/tc_debounce.sv
module tc_debounce #(
  parameter int W  = 1,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [W-1:0]  d,
  input  logic [CW-1:0] limit,
  output logic [W-1:0]  q
);

  logic [W-1:0]  cand_r, cand_n;
  logic [CW-1:0] cnt_r, cnt_n;
  logic [W-1:0]  q_r, q_n;

  always_comb begin
    cand_n = cand_r;
    cnt_n  = cnt_r;
    q_n    = q_r;
    if (d != cand_r) begin
      cand_n = d;
      cnt_n  = '0;
    end else if (cnt_r >= limit) begin
      q_n = cand_r;
    end else if (tick) begin
      cnt_n = cnt_r + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_r <= '0;
      cnt_r  <= '0;
      q_r    <= '0;
    end else begin
      cand_r <= cand_n;
      cnt_r  <= cnt_n;
      q_r    <= q_n;
    end
  end

  assign q = q_r;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_r != '0) |-> ((cnt_r == $past(cnt_r)) || (cnt_r == $past(cnt_r) + 1'b1)));

  a_r2_settle_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_r) |-> $past((d == cand_r) && (cnt_r >= limit)));

endmodule

// File: rtl/tc_deb_select.sv
module tc_deb_select #(
  parameter int CW    = 8,
  parameter int T_SEL0 = 168,
  parameter int T_SEL1 = 118,
  parameter int T_SEL2 = 134,
  parameter int T_SEL3 = 152
) (
  input  logic [1:0]    sel,
  output logic [CW-1:0] limit
);

  always_comb begin
    unique case (sel)
      2'b00:   limit = CW'(T_SEL0);
      2'b01:   limit = CW'(T_SEL1);
      2'b10:   limit = CW'(T_SEL2);
      default: limit = CW'(T_SEL3);
    endcase
  end

endmodule

// File: rtl/tc_attach_fsm.sv
module tc_attach_fsm
  import tc_attach_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       role_src,
  input  logic [5:0] cc_pair,
  input  logic       vbus_ok,
  output logic       attached,
  output logic       orient,
  output logic [1:0] cur_mode,
  output logic       id_n,
  output logic       audio_n
);

  att_state_e st_r, st_n;
  logic       orient_r, orient_n;
  logic [1:0] mode_r, mode_n;
  logic [2:0] s1, s2, act;

  assign s1  = cc_pair[2:0];
  assign s2  = cc_pair[5:3];
  assign act = orient_r ? s2 : s1;

  always_comb begin
    st_n     = st_r;
    orient_n = orient_r;
    mode_n   = mode_r;
    unique case (st_r)
      ST_IDLE: begin
        orient_n = 1'b0;
        mode_n   = 2'b00;
        if (role_src) begin
          if (s1 == CC_RD && s2 != CC_RD) begin
            st_n = ST_SRC;
          end else if (s2 == CC_RD && s1 != CC_RD) begin
            st_n     = ST_SRC;
            orient_n = 1'b1;
          end else if (s1 == CC_RA && s2 == CC_RA) begin
            st_n = ST_AUD;
          end
        end else if (vbus_ok) begin
          if (is_pullup(s1) && is_open(s2)) begin
            st_n   = ST_SNK;
            mode_n = pullup_mode(s1);
          end else if (is_pullup(s2) && is_open(s1)) begin
            st_n     = ST_SNK;
            orient_n = 1'b1;
            mode_n   = pullup_mode(s2);
          end
        end
      end
      ST_SRC: begin
        if (!(role_src && act == CC_RD)) begin
          st_n     = ST_IDLE;
          orient_n = 1'b0;
        end
      end
      ST_SNK: begin
        if (!role_src && vbus_ok && is_pullup(act)) begin
          mode_n = pullup_mode(act);
        end else begin
          st_n     = ST_IDLE;
          orient_n = 1'b0;
          mode_n   = 2'b00;
        end
      end
      default: begin
        if (!(role_src && s1 == CC_RA && s2 == CC_RA)) st_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r     <= ST_IDLE;
      orient_r <= 1'b0;
      mode_r   <= 2'b00;
    end else begin
      st_r     <= st_n;
      orient_r <= orient_n;
      mode_r   <= mode_n;
    end
  end

  assign attached = (st_r == ST_SRC) || (st_r == ST_SNK);
  assign orient   = orient_r;
  assign cur_mode = mode_r;
  assign id_n     = (st_r != ST_SRC);
  assign audio_n  = (st_r != ST_AUD);

  a_r5_audio_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(attached && !audio_n));

  a_r9_mode_sink_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != 2'b00) |-> (attached && id_n));

  a_r7_vbus_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (st_r == ST_SNK) |-> $past(vbus_ok));

  a_r8_clear_on_detach: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(attached) |-> (!orient && cur_mode == 2'b00));

  a_r3_id_source: assert property (@(posedge clk) disable iff (!rst_n)
    !id_n |-> (attached && $past(role_src)));

endmodule

// File: rtl/tc_attach_det.sv
module tc_attach_det #(
  parameter int DEB_SEL0 = 168,
  parameter int DEB_SEL1 = 118,
  parameter int DEB_SEL2 = 134,
  parameter int DEB_SEL3 = 152,
  parameter int VBUS_MS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       role_src,
  input  logic [1:0] deb_sel,
  input  logic [2:0] cc1_state,
  input  logic [2:0] cc2_state,
  input  logic       vbus_raw,
  output logic       attached,
  output logic       orient,
  output logic [1:0] cur_mode,
  output logic       id_n,
  output logic       audio_n
);

  localparam int MAX_A  = (DEB_SEL0 > DEB_SEL1) ? DEB_SEL0 : DEB_SEL1;
  localparam int MAX_B  = (DEB_SEL2 > DEB_SEL3) ? DEB_SEL2 : DEB_SEL3;
  localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CC_CW  = $clog2(MAX_T + 1);
  localparam int VB_CW  = $clog2(VBUS_MS + 1);

  logic             rsync1_r, rsync2_r, rst_i_n;
  logic [CC_CW-1:0] cc_limit;
  logic [5:0]       cc_raw, cc_stable;
  logic             vbus_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync1_r <= 1'b0;
      rsync2_r <= 1'b0;
    end else begin
      rsync1_r <= 1'b1;
      rsync2_r <= rsync1_r;
    end
  end
  assign rst_i_n = rsync2_r;

  assign cc_raw = {cc2_state, cc1_state};

  tc_deb_select #(
    .CW(CC_CW), .T_SEL0(DEB_SEL0), .T_SEL1(DEB_SEL1),
    .T_SEL2(DEB_SEL2), .T_SEL3(DEB_SEL3)
  ) u_sel (
    .sel   (deb_sel),
    .limit (cc_limit)
  );

  tc_debounce #(.W(6), .CW(CC_CW)) u_cc_deb (
    .clk   (clk),
    .rst_n (rst_i_n),
    .tick  (ms_tick),
    .d     (cc_raw),
    .limit (cc_limit),
    .q     (cc_stable)
  );

  tc_debounce #(.W(1), .CW(VB_CW)) u_vbus_deb (
    .clk   (clk),
    .rst_n (rst_i_n),
    .tick  (ms_tick),
    .d     (vbus_raw),
    .limit (VB_CW'(VBUS_MS)),
    .q     (vbus_ok)
  );

  tc_attach_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .role_src (role_src),
    .cc_pair  (cc_stable),
    .vbus_ok  (vbus_ok),
    .attached (attached),
    .orient   (orient),
    .cur_mode (cur_mode),
    .id_n     (id_n),
    .audio_n  (audio_n)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    (!rsync2_r) |=> (!attached && id_n && audio_n && cur_mode == 2'b00));

endmodule

// File: tb/tc_attach_det_test.sv
module tc_attach_det_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       role_src = 1'b1;
  logic [1:0] deb_sel = 2'b00;
  logic [2:0] cc1_state = 3'b000;
  logic [2:0] cc2_state = 3'b000;
  logic       vbus_raw = 1'b0;
  logic       attached, orient, id_n, audio_n;
  logic [1:0] cur_mode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int tick_per = 1;
  int tick_ctr = 0;
  bit cmp_on = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  tc_attach_det uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .role_src(role_src),
    .deb_sel(deb_sel), .cc1_state(cc1_state), .cc2_state(cc2_state),
    .vbus_raw(vbus_raw), .attached(attached), .orient(orient),
    .cur_mode(cur_mode), .id_n(id_n), .audio_n(audio_n)
  );

  // tick generator
  always @(negedge clk) begin
    ms_tick <= (tick_ctr == 0);
    tick_ctr <= (tick_ctr + 1 >= tick_per) ? 0 : tick_ctr + 1;
  end

  // behavioural reference model
  int m_rs1 = 0, m_rs2 = 0;
  int p_cand = 0, p_cnt = 0, p_stab = 0;
  int v_cand = 0, v_cnt = 0, v_stab = 0;
  int m_st = 0, m_or = 0, m_md = 0;

  function automatic bit f_pull(int c); return c == 4 || c == 5 || c == 6; endfunction
  function automatic bit f_open(int c); return !(c == 1 || c == 2 || f_pull(c)); endfunction
  function automatic int f_win(int s);
    case (s) 0: return 168; 1: return 118; 2: return 134; default: return 152; endcase
  endfunction

  always @(posedge clk) begin
    int old_rs2, c1, c2, a, d;
    old_rs2 = m_rs2;
    if (!rst_n) begin m_rs1 = 0; m_rs2 = 0; end
    else begin m_rs2 = m_rs1; m_rs1 = 1; end
    if (!old_rs2) begin
      p_cand = 0; p_cnt = 0; p_stab = 0;
      v_cand = 0; v_cnt = 0; v_stab = 0;
      m_st = 0; m_or = 0; m_md = 0;
    end else begin
      c1 = p_stab % 8; c2 = p_stab / 8;
      a = m_or ? c2 : c1;
      case (m_st)
        0: begin
          m_or = 0; m_md = 0;
          if (role_src) begin
            if (c1 == 2 && c2 != 2) m_st = 1;
            else if (c2 == 2 && c1 != 2) begin m_st = 1; m_or = 1; end
            else if (c1 == 1 && c2 == 1) m_st = 3;
          end else if (v_stab == 1) begin
            if (f_pull(c1) && f_open(c2)) begin m_st = 2; m_md = c1 - 3; end
            else if (f_pull(c2) && f_open(c1)) begin m_st = 2; m_or = 1; m_md = c2 - 3; end
          end
        end
        1: if (!(role_src && a == 2)) begin m_st = 0; m_or = 0; end
        2: if (!role_src && v_stab == 1 && f_pull(a)) m_md = a - 3;
           else begin m_st = 0; m_or = 0; m_md = 0; end
        default: if (!(role_src && c1 == 1 && c2 == 1)) m_st = 0;
      endcase
      d = cc2_state * 8 + cc1_state;
      if (d != p_cand) begin p_cand = d; p_cnt = 0; end
      else if (p_cnt >= f_win(deb_sel)) p_stab = p_cand;
      else if (ms_tick) p_cnt++;
      d = vbus_raw;
      if (d != v_cand) begin v_cand = d; v_cnt = 0; end
      else if (v_cnt >= 2) v_stab = v_cand;
      else if (ms_tick) v_cnt++;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      check("R3 model attached", attached, (m_st == 1 || m_st == 2));
      check("R4 model orient", orient, m_or);
      check("R6 model cur_mode", cur_mode, m_md);
      check("R9 model id_n", id_n, m_st != 1);
      check("R5 model audio_n", audio_n, m_st != 3);
    end
  end

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 100000 && !ended) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=%0d exp=0", cycles);
      finish_up();
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cc(int a, int b);
    @(negedge clk);
    cc1_state = 3'(a);
    cc2_state = 3'(b);
  endtask

  initial begin
    wait_n(4);
    // R1: outputs quiet while reset held
    check("R1 attached in reset", attached, 0);
    check("R1 id_n in reset", id_n, 1);
    rst_n = 1'b1;
    wait_n(3);
    cmp_on = 1;
    check("R1 attached after release", attached, 0);
    check("R1 cur_mode after release", cur_mode, 0);
    check("R1 audio_n after release", audio_n, 1);

    // R2 + R3: source, Rd on CC1, with a glitch restarting the count
    role_src = 1'b1; deb_sel = 2'b00;
    set_cc(2, 0);
    wait_n(100);
    set_cc(0, 0);
    set_cc(2, 0);
    wait_n(100);
    check("R2 glitch restarted debounce", attached, 0);
    wait_n(80);
    check("R3 source attach", attached, 1);
    check("R3 orient CC1", orient, 0);
    check("R3 id_n low", id_n, 0);
    check("R9 mode zero as source", cur_mode, 0);

    // R8: detach when the line opens
    set_cc(0, 0);
    wait_n(200);
    check("R8 detach attached", attached, 0);
    check("R8 detach id_n", id_n, 1);

    // R4: powered cable, Ra on CC1, Rd on CC2, shorter window
    deb_sel = 2'b01;
    set_cc(1, 2);
    wait_n(110);
    check("R2 window 118 not elapsed", attached, 0);
    wait_n(20);
    check("R4 cable attach", attached, 1);
    check("R4 orient follows Rd", orient, 1);
    set_cc(0, 0);
    wait_n(200);

    // R5: audio accessory
    deb_sel = 2'b10;
    set_cc(1, 1);
    wait_n(140);
    check("R5 audio_n low", audio_n, 0);
    check("R5 attached low", attached, 0);
    set_cc(0, 0);
    wait_n(200);
    check("R5 audio cleared", audio_n, 1);

    // R7 + R6: sink, 3 A pull-up on CC2
    role_src = 1'b0; deb_sel = 2'b00;
    set_cc(0, 6);
    wait_n(200);
    check("R7 no attach without vbus", attached, 0);
    @(negedge clk) vbus_raw = 1'b1;
    wait_n(2);
    check("R7 vbus still debouncing", attached, 0);
    wait_n(4);
    check("R6 sink attach", attached, 1);
    check("R6 orient CC2", orient, 1);
    check("R6 mode high", cur_mode, 3);
    check("R9 id_n high as sink", id_n, 1);

    // R8: vbus loss detaches
    @(negedge clk) vbus_raw = 1'b0;
    wait_n(6);
    check("R8 vbus loss detach", attached, 0);
    check("R8 mode cleared", cur_mode, 0);
    set_cc(0, 0);
    wait_n(200);

    // R2 + R6: sparse tick, window 152, 1.5 A on CC1
    tick_per = 4; deb_sel = 2'b11;
    @(negedge clk) vbus_raw = 1'b1;
    wait_n(20);
    set_cc(5, 0);
    wait_n(560);
    check("R2 sparse tick not elapsed", attached, 0);
    wait_n(100);
    check("R6 sparse attach", attached, 1);
    check("R6 mode medium", cur_mode, 2);
    check("R6 orient CC1", orient, 0);

    // R10: role change clears, pull-ups ignored as source
    @(negedge clk) role_src = 1'b1;
    wait_n(3);
    check("R10 role change detach", attached, 0);
    wait_n(200);
    check("R10 pull-up ignored as source", attached, 0);
    check("R10 id_n stays high", id_n, 1);

    wait_n(5);
    finish_up();
  end

endmodule